// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns one 32-bit virtual address into a physical address. For each request it reads at most two descriptor words from memory through a small request/response port. Before translation it moves low addresses into a per-process window. It then gates the access through a 2-bit domain field and selects the access-permission pair that covers the addressed part of the page. The pair is decoded for user or privileged loads, stores and instruction fetches.

A request is taken only while the walker is idle. Only one translation is in flight at a time. Every request ends with a one-cycle completion pulse, which carries either a physical address and a permission vector or a fault. A fault also loads an 8-bit status and the original virtual address into a register pair. Instruction fetches use one pair and loads and stores use the other. With translation switched off, the walker does no memory reads and answers on the cycle after it accepts the request.

Top module: `ptw_walker`

## Requirements
- R1: A virtual address below 0x0200_0000 has the process offset `req_pid` added to it before any further use. Addresses at or above that bound pass unchanged.
- R2: When `req_mmu_en` is 0, the walker issues no memory read. `done_valid` rises on the cycle after acceptance. It reports no fault, `done_paddr` equal to the relocated address, and `done_prot` = 2'b11.
- R3: The first read goes to {`req_ttb`[31:14], relocated address[31:20], 2'b00}.
- R4: A first-level word whose bits 1:0 are 0 or 3 ends the walk with code 5.
- R5: The domain number is bits 8:5 of the first-level word. Its field is `req_dacr`[2d+1:2d]. Field values 0 and 2 fault with code 9 for a section (type 2) and code 11 for a table (type 1). The table fault happens before any second read. Field value 3 skips the permission check and grants 2'b11.
- R6: A section (type 2) yields {word[31:20], address[19:0]} and takes its permission pair from word bits 11:10.
- R7: For a type-1 word, the second read goes to {word[31:10], address[19:12], 2'b00}. A second-level word with bits 1:0 = 0 ends the walk with code 7.
- R8: Second-level type 1 is a 64 KB page: {w[31:16], a[15:0]}, with the pair at bit 4+2·a[15:14]. Type 2 is a 4 KB page: {w[31:12], a[11:0]}, with the pair at bit 4+2·a[11:10]. Type 3 is a 1 KB page: {w[31:10], a[9:0]}, with the pair at bits 5:4.
- R9: `done_prot` bit 0 is read and bit 1 is write. `req_acc` encodes 0 as load, 1 as store and 2 as fetch, and a fetch is judged as a read. The pair decodes as follows. Pair 0: stores are never allowed. Otherwise, with only `req_sys_prot` set it gives read for privileged accesses and nothing for user accesses. With only `req_rom_prot` set it gives read for everyone. With both or neither set it gives nothing. Pair 1: privileged accesses get 2'b11 and user accesses get nothing. Pair 2: privileged accesses get 2'b11, user loads and fetches get 2'b01, and user stores get nothing. Pair 3: 2'b11.
- R10: A permission result of 2'b00 is a fault: code 13 for a section and code 15 for a page. On any fault `done_prot` is 2'b00.
- R11: The fault status is {domain number, code}. A fetch fault writes `ifsr` and `ifar`. Any other fault writes `dfsr` and `dfar`. The address written is the virtual address before relocation, and the other pair keeps its value.
- R12: `req_ready` is high only when idle. `done_valid` lasts exactly one cycle, after which the walker is idle again. A memory request keeps its valid and address unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Access made from user level |
| req_ttb | input | 32 | First-level table base |
| req_dacr | input | 32 | Sixteen 2-bit domain fields |
| req_pid | input | 32 | Process relocation offset |
| req_mmu_en | input | 1 | Translation enable |
| req_sys_prot | input | 1 | Privileged-read control for pair 0 |
| req_rom_prot | input | 1 | Read-for-all control for pair 0 |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 32 | Descriptor word |
| done_valid | output | 1 | Completion pulse |
| done_fault | output | 1 | Translation failed |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_prot | output | 2 | Bit 1 write, bit 0 read |
| ifsr | output | 8 | Fetch fault status |
| ifar | output | 32 | Fetch fault address |
| dfsr | output | 8 | Data fault status |
| dfar | output | 32 | Data fault address |

## Verification
The assertions assume that memory returns each descriptor at least one cycle after it accepts the read, and that it never returns a word that was not requested. The bench memory model follows this rule. It accepts after a chosen stall and answers exactly one cycle later. The assertions also assume that requests arrive only while `req_ready` is high. The bench drives each request at a falling edge seen as idle and drops it after one cycle. The table contents are built so that every descriptor type, domain field, pair position and control-bit setting is reached. The bench's reference model predicts each result and each descriptor address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam logic [1:0] ACC_LOAD   = 2'd0;
   localparam logic [1:0] ACC_STORE  = 2'd1;
   localparam logic [1:0] ACC_FETCH  = 2'd2;
   localparam logic [1:0] DA_MANAGER = 2'd3;

   localparam logic [3:0] FC_XLAT_SEC  = 4'd5;
   localparam logic [3:0] FC_XLAT_PAGE = 4'd7;
   localparam logic [3:0] FC_DOM_SEC   = 4'd9;
   localparam logic [3:0] FC_DOM_PAGE  = 4'd11;
   localparam logic [3:0] FC_PERM_SEC  = 4'd13;
   localparam logic [3:0] FC_PERM_PAGE = 4'd15;

   localparam logic [1:0] L1_SECTION = 2'b10;
   localparam logic [1:0] L1_TABLE   = 2'b01;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_L1   = 2'd1,
      ST_L2   = 2'd2,
      ST_DONE = 2'd3
   } walk_state_e;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
   import ptw_pkg::*;
(
   input  logic [1:0] ap,
   input  logic [1:0] dom_acc,
   input  logic [1:0] acc,
   input  logic       user,
   input  logic       sys_prot,
   input  logic       rom_prot,
   output logic [1:0] prot
);
   logic is_store;
   assign is_store = (acc == ACC_STORE);

   always_comb begin
      prot = 2'b00;
      if (dom_acc == DA_MANAGER) begin
         prot = 2'b11;
      end else begin
         unique case (ap)
            2'd0: begin
               if (!is_store) begin
                  if (sys_prot && !rom_prot)      prot = user ? 2'b00 : 2'b01;
                  else if (rom_prot && !sys_prot) prot = 2'b01;
               end
            end
            2'd1:    prot = user ? 2'b00 : 2'b11;
            2'd2:    prot = user ? (is_store ? 2'b00 : 2'b01) : 2'b11;
            default: prot = 2'b11;
         endcase
      end
   end

   always_comb begin
      AST_MANAGER_FULL: assert (dom_acc != DA_MANAGER || prot == 2'b11); // R5
      AST_USER_AP1_NONE: assert (!(user && ap == 2'd1 && dom_acc != DA_MANAGER) || prot == 2'b00); // R9
   end
endmodule

// File: rtl/ptw_l2dec.sv
module ptw_l2dec #(
   parameter bit TINY_EN = 1'b1
) (
   input  logic [1:0]  l2_type,
   input  logic [31:4] l2_desc,
   input  logic [15:0] va_lo,
   output logic        pg_fault,
   output logic [31:0] pg_paddr,
   output logic [1:0]  pg_ap
);
   localparam int AP_FIELDS_W = 8;

   logic [AP_FIELDS_W-1:0] ap_fields;
   logic [2:0]             sel_large;
   logic [2:0]             sel_small;
   logic                   tiny_fault;
   logic [31:0]            tiny_paddr;
   logic [1:0]             tiny_ap;

   assign ap_fields = l2_desc[11:4];
   assign sel_large = {va_lo[15:14], 1'b0};
   assign sel_small = {va_lo[11:10], 1'b0};

   generate
      if (TINY_EN) begin : g_tiny
         assign tiny_fault = 1'b0;
         assign tiny_paddr = {l2_desc[31:10], va_lo[9:0]};
         assign tiny_ap    = l2_desc[5:4];
      end else begin : g_no_tiny
         assign tiny_fault = 1'b1;
         assign tiny_paddr = '0;
         assign tiny_ap    = '0;
      end
   endgenerate

   always_comb begin
      pg_fault = 1'b0;
      pg_paddr = '0;
      pg_ap    = '0;
      unique case (l2_type)
         2'd0: pg_fault = 1'b1;
         2'd1: begin
            pg_paddr = {l2_desc[31:16], va_lo[15:0]};
            pg_ap    = ap_fields[sel_large +: 2];
         end
         2'd2: begin
            pg_paddr = {l2_desc[31:12], va_lo[11:0]};
            pg_ap    = ap_fields[sel_small +: 2];
         end
         default: begin
            pg_fault = tiny_fault;
            pg_paddr = tiny_paddr;
            pg_ap    = tiny_ap;
         end
      endcase
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int DW             = 32,
   parameter int FCSE_SPAN_LOG2 = 25,
   parameter bit TINY_EN        = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [DW-1:0] req_vaddr,
   input  logic [1:0]    req_acc,
   input  logic          req_user,
   input  logic [DW-1:0] req_ttb,
   input  logic [DW-1:0] req_dacr,
   input  logic [DW-1:0] req_pid,
   input  logic          req_mmu_en,
   input  logic          req_sys_prot,
   input  logic          req_rom_prot,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [DW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          done_valid,
   output logic          done_fault,
   output logic [DW-1:0] done_paddr,
   output logic [1:0]    done_prot,
   output logic [7:0]    ifsr,
   output logic [DW-1:0] ifar,
   output logic [7:0]    dfsr,
   output logic [DW-1:0] dfar
);
   localparam int TTB_LSB   = 14;
   localparam int SEC_SHIFT = 20;
   localparam int TBL_LSB   = 10;
   localparam int PG_SHIFT  = 12;
   localparam int DOM_LSB   = 5;
   localparam int DOM_W     = 4;
   localparam int FSR_W     = 8;

   if (DW != 32) begin : g_bad_dw
      $error("ptw_walker: descriptor layout needs DW == 32");
   end
   if (FCSE_SPAN_LOG2 < 1 || FCSE_SPAN_LOG2 >= DW) begin : g_bad_span
      $error("ptw_walker: FCSE_SPAN_LOG2 out of range");
   end

   walk_state_e           state_q;
   logic                  pend_q;
   logic [DW-1:0]         va_q, va_orig_q, dacr_q, mem_addr_q;
   logic [1:0]            acc_q, dacc_q;
   logic                  user_q, sys_q, rom_q;
   logic [DOM_W-1:0]      dom_q;
   logic [DW-1:0]         res_paddr_q;
   logic [1:0]            res_prot_q;
   logic                  res_fault_q;
   logic [FSR_W-1:0]      ifsr_q, dfsr_q;
   logic [DW-1:0]         ifar_q, dfar_q;

   logic [DW-1:0]         va_rel;
   logic                  rsp_hit;
   logic [DOM_W-1:0]      l1_dom;
   logic [1:0]            l1_dacc;
   logic                  pg_fault;
   logic [DW-1:0]         pg_paddr;
   logic [1:0]            pg_ap;
   logic [1:0]            perm_ap, perm_dacc, perm_prot;
   logic                  fin, fin_fault, go_l2;
   logic [3:0]            fin_code;
   logic [DOM_W-1:0]      fin_dom;
   logic [DW-1:0]         fin_paddr;
   logic [1:0]            fin_prot;
   logic                  sink_unused;

   assign sink_unused = ^{mem_rsp_data[4:2], mem_rsp_data[9], va_q[DW-1:SEC_SHIFT]};

   // Process relocation for the low window
   assign va_rel = (~|req_vaddr[DW-1:FCSE_SPAN_LOG2]) ? (req_vaddr + req_pid) : req_vaddr;

   assign rsp_hit = pend_q && mem_rsp_valid;
   assign l1_dom  = mem_rsp_data[DOM_LSB +: DOM_W];
   assign l1_dacc = dacr_q[{l1_dom, 1'b0} +: 2];

   ptw_l2dec #(.TINY_EN(TINY_EN)) u_l2dec (
      .l2_type  (mem_rsp_data[1:0]),
      .l2_desc  (mem_rsp_data[31:4]),
      .va_lo    (va_q[15:0]),
      .pg_fault (pg_fault),
      .pg_paddr (pg_paddr),
      .pg_ap    (pg_ap)
   );

   assign perm_ap   = (state_q == ST_L2) ? pg_ap  : mem_rsp_data[11:10];
   assign perm_dacc = (state_q == ST_L2) ? dacc_q : l1_dacc;

   ptw_perm u_perm (
      .ap       (perm_ap),
      .dom_acc  (perm_dacc),
      .acc      (acc_q),
      .user     (user_q),
      .sys_prot (sys_q),
      .rom_prot (rom_q),
      .prot     (perm_prot)
   );

   always_comb begin
      fin       = 1'b0;
      fin_fault = 1'b0;
      fin_code  = '0;
      fin_dom   = '0;
      fin_paddr = '0;
      fin_prot  = '0;
      go_l2     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid && !req_mmu_en) begin
               fin       = 1'b1;
               fin_paddr = va_rel;
               fin_prot  = 2'b11;
            end
         end
         ST_L1: begin
            if (rsp_hit) begin
               fin_dom = l1_dom;
               if (mem_rsp_data[1:0] == L1_SECTION) begin
                  fin = 1'b1;
                  if (!l1_dacc[0]) begin
                     fin_fault = 1'b1;
                     fin_code  = FC_DOM_SEC;
                  end else if (perm_prot == 2'b00) begin
                     fin_fault = 1'b1;
                     fin_code  = FC_PERM_SEC;
                  end else begin
                     fin_paddr = {mem_rsp_data[DW-1:SEC_SHIFT], va_q[SEC_SHIFT-1:0]};
                     fin_prot  = perm_prot;
                  end
               end else if (mem_rsp_data[1:0] == L1_TABLE) begin
                  if (!l1_dacc[0]) begin
                     fin       = 1'b1;
                     fin_fault = 1'b1;
                     fin_code  = FC_DOM_PAGE;
                  end else begin
                     go_l2 = 1'b1;
                  end
               end else begin
                  fin       = 1'b1;
                  fin_fault = 1'b1;
                  fin_code  = FC_XLAT_SEC;
               end
            end
         end
         ST_L2: begin
            if (rsp_hit) begin
               fin     = 1'b1;
               fin_dom = dom_q;
               if (pg_fault) begin
                  fin_fault = 1'b1;
                  fin_code  = FC_XLAT_PAGE;
               end else if (perm_prot == 2'b00) begin
                  fin_fault = 1'b1;
                  fin_code  = FC_PERM_PAGE;
               end else begin
                  fin_paddr = pg_paddr;
                  fin_prot  = perm_prot;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= 1'b0;
         va_q        <= '0;
         va_orig_q   <= '0;
         dacr_q      <= '0;
         mem_addr_q  <= '0;
         acc_q       <= ACC_LOAD;
         dacc_q      <= '0;
         user_q      <= 1'b0;
         sys_q       <= 1'b0;
         rom_q       <= 1'b0;
         dom_q       <= '0;
         res_paddr_q <= '0;
         res_prot_q  <= '0;
         res_fault_q <= 1'b0;
         ifsr_q      <= '0;
         dfsr_q      <= '0;
         ifar_q      <= '0;
         dfar_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q       <= va_rel;
                  va_orig_q  <= req_vaddr;
                  acc_q      <= req_acc;
                  user_q     <= req_user;
                  dacr_q     <= req_dacr;
                  sys_q      <= req_sys_prot;
                  rom_q      <= req_rom_prot;
                  mem_addr_q <= {req_ttb[DW-1:TTB_LSB], va_rel[DW-1:SEC_SHIFT], 2'b00};
                  pend_q     <= 1'b0;
                  state_q    <= req_mmu_en ? ST_L1 : ST_DONE;
               end
            end
            ST_L1, ST_L2: begin
               if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
               if (go_l2) begin
                  mem_addr_q <= {mem_rsp_data[DW-1:TBL_LSB], va_q[SEC_SHIFT-1:PG_SHIFT], 2'b00};
                  dom_q      <= l1_dom;
                  dacc_q     <= l1_dacc;
                  pend_q     <= 1'b0;
                  state_q    <= ST_L2;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (fin) begin
            state_q     <= ST_DONE;
            pend_q      <= 1'b0;
            res_paddr_q <= fin_paddr;
            res_prot_q  <= fin_prot;
            res_fault_q <= fin_fault;
            if (fin_fault) begin
               if (acc_q == ACC_FETCH) begin
                  ifsr_q <= {fin_dom, fin_code};
                  ifar_q <= va_orig_q;
               end else begin
                  dfsr_q <= {fin_dom, fin_code};
                  dfar_q <= va_orig_q;
               end
            end
         end
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = ((state_q == ST_L1) || (state_q == ST_L2)) && !pend_q;
   assign mem_req_addr  = mem_addr_q;
   assign done_valid    = (state_q == ST_DONE);
   assign done_fault    = res_fault_q;
   assign done_paddr    = res_paddr_q;
   assign done_prot     = res_prot_q;
   assign ifsr          = ifsr_q;
   assign ifar          = ifar_q;
   assign dfsr          = dfsr_q;
   assign dfar          = dfar_q;

   AST_BYPASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !req_mmu_en) |=> (done_valid && !done_fault && done_prot == 2'b11 && !mem_req_valid)); // R2
   AST_FAULT_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault) |-> (done_prot == 2'b00)); // R10
   AST_DFSR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (dfsr != 8'h00) |-> (dfsr[0] && dfsr[3:0] >= 4'd5)); // R11
   AST_IFSR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ifsr != 8'h00) |-> (ifsr[0] && ifsr[3:0] >= 4'd5)); // R11
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready)); // R12
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [31:0] req_ttb = '0, req_dacr = '0, req_pid = '0;
   logic        req_mmu_en = 1'b0, req_sys_prot = 1'b0, req_rom_prot = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done_valid, done_fault;
   logic [31:0] done_paddr;
   logic [1:0]  done_prot;
   logic [7:0]  ifsr, dfsr;
   logic [31:0] ifar, dfar;

   always #2.5 clk = ~clk;

   ptw_walker u_ptw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user), .req_ttb(req_ttb),
      .req_dacr(req_dacr), .req_pid(req_pid), .req_mmu_en(req_mmu_en),
      .req_sys_prot(req_sys_prot), .req_rom_prot(req_rom_prot),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr),
      .done_prot(done_prot), .ifsr(ifsr), .ifar(ifar), .dfsr(dfsr), .dfar(dfar)
   );

   int          n_tests = 0, n_fail = 0;
   bit          finished = 1'b0;
   int          stall = 0;
   logic [31:0] pmem [logic [31:0]];
   logic [31:0] alog [$];
   logic [7:0]  e_ifsr = '0, e_dfsr = '0;
   logic [31:0] e_ifar = '0, e_dfar = '0;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Permission table taken from R9
   function automatic logic [1:0] ref_perm(input int ap, input int da, input int acc,
                                           input bit usr, input bit s, input bit r);
      if (da == 3) return 2'b11;
      if (ap == 3) return 2'b11;
      if (ap == 1) return usr ? 2'b00 : 2'b11;
      if (ap == 2) begin
         if (!usr) return 2'b11;
         return (acc == 1) ? 2'b00 : 2'b01;
      end
      if (acc == 1) return 2'b00;
      if (s && !r) return usr ? 2'b00 : 2'b01;
      if (r && !s) return 2'b01;
      return 2'b00;
   endfunction

   // Behavioural reference walk
   task automatic ref_xlat(input logic [31:0] va, input int acc, input bit usr,
                           output bit flt, output logic [7:0] fsr, output logic [31:0] pa,
                           output logic [1:0] prot, output int nrd,
                           output logic [31:0] a1, output logic [31:0] a2);
      logic [31:0] v, d1, d2;
      int dom, da, ap;
      bit page;
      flt = 0; fsr = 0; pa = 0; prot = 0; nrd = 0; a1 = 0; a2 = 0; page = 0;
      v = (va < 32'h0200_0000) ? va + req_pid : va;
      if (!req_mmu_en) begin pa = v; prot = 2'b11; return; end
      a1 = (req_ttb & 32'hFFFF_C000) | ((v >> 18) & 32'h3FFC);
      nrd = 1;
      d1 = rd(a1);
      dom = int'((d1 >> 5) & 15);
      da = int'((req_dacr >> (2 * dom)) & 3);
      if (d1[1:0] == 2'd0 || d1[1:0] == 2'd3) begin
         flt = 1; fsr = 8'(5 + 16 * dom); return;
      end
      if (da == 0 || da == 2) begin
         flt = 1; fsr = 8'(((d1[1:0] == 2'd2) ? 9 : 11) + 16 * dom); return;
      end
      if (d1[1:0] == 2'd2) begin
         pa = (d1 & 32'hFFF0_0000) | (v & 32'h000F_FFFF);
         ap = int'((d1 >> 10) & 3);
      end else begin
         page = 1;
         a2 = (d1 & 32'hFFFF_FC00) | ((v >> 10) & 32'h3FC);
         nrd = 2;
         d2 = rd(a2);
         case (d2[1:0])
            2'd0: begin flt = 1; fsr = 8'(7 + 16 * dom); return; end
            2'd1: begin pa = (d2 & 32'hFFFF_0000) | (v & 32'hFFFF);
                        ap = int'((d2 >> (4 + 2 * ((v >> 14) & 3))) & 3); end
            2'd2: begin pa = (d2 & 32'hFFFF_F000) | (v & 32'hFFF);
                        ap = int'((d2 >> (4 + 2 * ((v >> 10) & 3))) & 3); end
            default: begin pa = (d2 & 32'hFFFF_FC00) | (v & 32'h3FF);
                        ap = int'((d2 >> 4) & 3); end
         endcase
      end
      prot = ref_perm(ap, da, acc, usr, req_sys_prot, req_rom_prot);
      if (prot == 2'b00) begin
         flt = 1; pa = 0; fsr = 8'((page ? 15 : 13) + 16 * dom);
      end
   endtask

   // Memory model: accepts after `stall` cycles, answers one cycle later
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rst_n && mem_req_valid) begin
            repeat (stall) @(negedge clk);
            mem_req_ready = 1'b1;
            alog.push_back(mem_req_addr);
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(alog[alog.size()-1]);
         end
      end
   end

   task automatic xlat(input logic [31:0] va, input int acc, input bit usr, input string tag);
      bit flt; logic [7:0] fsr; logic [31:0] pa, a1, a2; logic [1:0] prot; int nrd, n;
      ref_xlat(va, acc, usr, flt, fsr, pa, prot, nrd, a1, a2);
      alog.delete();
      @(negedge clk);
      chk(req_ready == 1'b1, "R12", "ready before request", 32'(req_ready), 32'd1);
      req_vaddr = va; req_acc = 2'(acc); req_user = usr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done_valid && n < 300) begin @(negedge clk); n++; end
      if (!done_valid) begin
         chk(1'b0, tag, "completion timeout", 32'(n), 32'd0);
         return;
      end
      if (!req_mmu_en) chk(n == 0, "R2", "bypass latency", 32'(n), 32'd0);
      chk(done_fault == flt, tag, "fault flag", 32'(done_fault), 32'(flt));
      chk(done_prot == prot, tag, "permission", 32'(done_prot), 32'(prot));
      if (!flt) chk(done_paddr == pa, tag, "physical address", done_paddr, pa);
      else if (acc == 2) begin e_ifsr = fsr; e_ifar = va; end
      else begin e_dfsr = fsr; e_dfar = va; end
      chk(ifsr == e_ifsr, "R11", {tag, " ifsr"}, 32'(ifsr), 32'(e_ifsr));
      chk(ifar == e_ifar, "R11", {tag, " ifar"}, ifar, e_ifar);
      chk(dfsr == e_dfsr, "R11", {tag, " dfsr"}, 32'(dfsr), 32'(e_dfsr));
      chk(dfar == e_dfar, "R11", {tag, " dfar"}, dfar, e_dfar);
      chk(alog.size() == nrd, "R3", {tag, " read count"}, 32'(alog.size()), 32'(nrd));
      if (nrd >= 1 && alog.size() >= 1) chk(alog[0] == a1, "R3", {tag, " first address"}, alog[0], a1);
      if (nrd == 2 && alog.size() >= 2) chk(alog[1] == a2, "R7", {tag, " second address"}, alog[1], a2);
      @(negedge clk);
      chk(done_valid == 1'b0 && req_ready == 1'b1, "R12", "single pulse then idle",
          32'({done_valid, req_ready}), 32'b01);
   endtask

   function automatic logic [31:0] sec(input logic [31:0] base, input int dom, input int ap);
      return (base & 32'hFFF0_0000) | 32'(ap << 10) | 32'(dom << 5) | 32'h2;
   endfunction

   initial begin
      // Tables: first level at 0x4000, coarse table at 0x0001_0000
      req_ttb  = 32'h0000_4000;
      req_dacr = 32'h1 | (32'h1 << 2) | (32'h0 << 4) | (32'h1 << 6) | (32'h1 << 8)
               | (32'h2 << 10) | (32'h3 << 12);
      pmem[32'h4000 + 4*0]     = sec(32'h8000_0000, 0, 3);
      pmem[32'h4000 + 4*1]     = 32'h0001_0000 | (1 << 5) | 1;
      pmem[32'h4000 + 4*2]     = 32'h0000_0000 | (3 << 5);
      pmem[32'h4000 + 4*3]     = sec(32'h8100_0000, 2, 3);
      pmem[32'h4000 + 4*4]     = sec(32'h8200_0000, 4, 0);
      pmem[32'h4000 + 4*5]     = sec(32'h8300_0000, 4, 1);
      pmem[32'h4000 + 4*6]     = sec(32'h8400_0000, 4, 2);
      pmem[32'h4000 + 4*7]     = 32'h0001_0000 | (5 << 5) | 1;
      pmem[32'h4000 + 4*8]     = sec(32'h8500_0000, 6, 0);
      pmem[32'h4000 + 4*9]     = 32'h0000_0003 | (3 << 5);
      pmem[32'h4000 + 4*'h50]  = sec(32'hC050_0000, 0, 3);
      pmem[32'h4000 + 4*'h100] = sec(32'h9ab0_0000, 3, 3);
      pmem[32'h0001_0000 + 4*1] = 32'h9040_0000 | (32'hE4 << 4) | 2;
      pmem[32'h0001_0000 + 4*2] = 32'hA001_0000 | (32'hE4 << 4) | 1;
      pmem[32'h0001_0000 + 4*3] = 32'hB000_0400 | (32'h2 << 4) | 3;

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0 || req_ready == 1'b1, "R12", "ready known in reset", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && done_valid == 1'b0 && mem_req_valid == 1'b0, "R12", "reset state",
          32'({req_ready, done_valid, mem_req_valid}), 32'b100);
      chk(ifsr == 0 && dfsr == 0, "R11", "status after reset", 32'({ifsr, dfsr}), 32'd0);

      // R2: translation off
      req_mmu_en = 1'b0; req_pid = 32'h0070_0000;
      xlat(32'h0000_1234, 1, 1, "R2");
      xlat(32'h7654_3210, 0, 0, "R2");
      req_mmu_en = 1'b1; req_pid = 32'h0;

      // R1: relocation below and at the window bound
      req_pid = 32'h0500_0000;
      xlat(32'h0000_1234, 0, 1, "R1");
      xlat(32'h01FF_FFFC, 0, 1, "R1");
      xlat(32'h0500_0abc, 0, 1, "R1");
      req_pid = 32'h0;

      xlat(32'h0020_0010, 0, 0, "R4");
      xlat(32'h0090_0010, 2, 0, "R4");
      xlat(32'h0030_0000, 0, 0, "R5");
      xlat(32'h0070_4000, 2, 0, "R5");
      xlat(32'h0080_0000, 1, 1, "R5");
      xlat(32'h1000_5678, 1, 1, "R6");
      xlat(32'h0010_0abc, 0, 0, "R7");
      xlat(32'h0010_1c00, 0, 0, "R8");
      xlat(32'h0010_2400, 0, 0, "R8");
      xlat(32'h0010_3333, 0, 0, "R8");
      xlat(32'h0050_0000, 0, 1, "R10");
      xlat(32'h0010_1000, 2, 1, "R10");
      xlat(32'h0010_1000, 1, 0, "R11");

      // R9 sweep over pair values, access types, levels and control bits; R12 stalls
      for (int sr = 0; sr < 4; sr++) begin
         req_sys_prot = sr[0]; req_rom_prot = sr[1];
         for (int reg_i = 0; reg_i < 10; reg_i++) begin
            for (int acc = 0; acc < 3; acc++) begin
               for (int u = 0; u < 2; u++) begin
                  stall = (reg_i + acc + u) % 3;
                  xlat(32'(reg_i << 20) | 32'h0000_1000 * 32'(acc + 1) | 32'(u << 14), acc, u[0], "R9");
               end
            end
         end
         for (int pg = 1; pg < 4; pg++) begin
            for (int sub = 0; sub < 4; sub++) begin
               xlat(32'h0010_0000 | 32'(pg << 12) | 32'(sub << 10) | 32'(sub << 14), sr % 3, sr[0], "R8");
            end
         end
      end
      stall = 0;

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL R12 watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule